// File: doc/BRIEF.md
# Protected Page-Write EEPROM Controller

This block is a synchronous, clock-sampled model of a byte-wide parallel EEPROM with page programming. The host drives an active-low chip enable, an active-low output enable, an active-low write strobe, an address bus and a shared bidirectional data bus. Each byte write, called a load here, is gathered into a page buffer. An inactivity timer restarts on every load. When it runs out, a self-timed program cycle commits the whole page to the internal storage array in one step. Byte positions that were never loaded are written as FFh.

Writing can be fenced off by a three-byte key sequence. Once the key has been issued, protection stays on, and every later issue of the key opens exactly one page program. A six-byte key starts a self-timed erase that sets the whole array to FFh. While an operation runs, array reads are replaced by a status byte. That byte carries a polarity bit and a toggle bit, so the host can poll for the end of the operation. All durations are given in clock cycles by parameters.

Top module: `pgw_eeprom`

## Requirements
- R1: `dq` is driven by the block only while `ce_n` and `oe_n` are both 0. When idle, the value driven is the array byte at `addr`. In every other case the block leaves `dq` undriven.
- R2: A load is a strobe during which `ce_n`=0, `we_n`=0 and `oe_n`=1. The address is the value of `addr` in the first cycle of the strobe. The data is the value of `dq` in the last cycle of the strobe. The load takes effect on the clock edge that sees the strobe released.
- R3: After reset the array reads FFh and protection is off, so every load is buffered. A program cycle starts (`busy` rises) exactly IDLE_CYC clock edges after the edge on which the last buffered load took effect.
- R4: A load that begins before the idle timer expires restarts it. This is true even when the strobe begins on the very cycle of expiry. Loading the same page offset again replaces the buffered byte.
- R5: The byte offset within a page is `addr[PAGE_W-1:0]`. The page written is `addr[ADDR_W-1:PAGE_W]` of the last buffered load. Offsets not loaded are programmed as FFh.
- R6: The key sequence is AAh to address 5555h, then 55h to 2AAAh, then A0h to 5555h, with addresses compared on their low ADDR_W bits. It turns protection on, and protection then never turns off before reset. The key bytes are never written to the array.
- R7: While protection is on and no key has been issued since the last program cycle, loads are discarded and no program cycle starts.
- R8: After a key, the next page load is programmed. When that program cycle ends, loads are discarded again.
- R9: A load that does not match the next expected key step returns the matcher to its idle state. That load is then handled as ordinary data, so it is discarded if writing is locked.
- R10: `busy` stays high for exactly PROG_CYC cycles during a program cycle. Loads issued while `busy` is high are ignored. All buffered bytes appear in the array together when `busy` falls.
- R11: A read while programming returns a status byte. Bit 7 is the inverse of bit 7 of the last buffered byte. Bit 6 inverts after each completed read. Bits 5..0 are 0.
- R12: The sequence AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h starts an erase whatever the protection state. The erase holds `busy` for ERASE_CYC cycles and leaves every array byte at FFh. Status reads during the erase return bit 7 = 0 and the same toggling bit 6.
- R13: Key matching is suspended while the page buffer holds any byte. In that state, key-shaped loads are buffered as data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Byte address |
| dq | inout | 8 | Bidirectional data bus |
| busy | output | 1 | High while a program or erase cycle runs |

## Verification
The idle timer's expiry and the start of a fresh load can fall on the same cycle. The new load must win, so no program cycle starts. The bench provokes this by placing the next strobe so that its first low cycle lands on the edge where the counter would reach its limit. It then judges the outcome from the ports: `busy` must stay low, a later launch must come a full IDLE_CYC after the second load, and both bytes must be present in the array afterwards. A second overlap, a load arriving while a program cycle runs, is judged by reading back the untouched array byte.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
   typedef enum logic [1:0] {OP_IDLE, OP_PROG, OP_ERASE} op_e;
   typedef enum logic [2:0] {SQ_IDLE, SQ_K1, SQ_K2, SQ_E3, SQ_E4, SQ_E5} seq_e;

   localparam logic [15:0] KEY_ADDR_P = 16'h5555;
   localparam logic [15:0] KEY_ADDR_Q = 16'h2AAA;
   localparam logic [7:0]  KEY_LEAD   = 8'hAA;
   localparam logic [7:0]  KEY_MID    = 8'h55;
   localparam logic [7:0]  KEY_WRITE  = 8'hA0;
   localparam logic [7:0]  KEY_ERPRE  = 8'h80;
   localparam logic [7:0]  KEY_ERASE  = 8'h10;
endpackage

// File: rtl/pgw_seq.sv
module pgw_seq
   import pgw_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev,
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        data,
   output logic              step_ok,
   output logic              do_unlock,
   output logic              do_erase
);
   localparam logic [ADDR_W-1:0] AP = KEY_ADDR_P[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] AQ = KEY_ADDR_Q[ADDR_W-1:0];

   seq_e st_q, st_d;
   logic ok_c, unl_c, ers_c;
   logic at_p, at_q;

   assign at_p = (addr == AP);
   assign at_q = (addr == AQ);

   always_comb begin
      st_d  = SQ_IDLE;
      ok_c  = 1'b0;
      unl_c = 1'b0;
      ers_c = 1'b0;
      case (st_q)
         SQ_IDLE: if (at_p && data == KEY_LEAD) begin st_d = SQ_K1; ok_c = 1'b1; end
         SQ_K1:   if (at_q && data == KEY_MID)  begin st_d = SQ_K2; ok_c = 1'b1; end
         SQ_K2: begin
            if (at_p && data == KEY_WRITE) begin
               ok_c  = 1'b1;
               unl_c = 1'b1;
            end else if (at_p && data == KEY_ERPRE) begin
               st_d = SQ_E3;
               ok_c = 1'b1;
            end
         end
         SQ_E3:   if (at_p && data == KEY_LEAD) begin st_d = SQ_E4; ok_c = 1'b1; end
         SQ_E4:   if (at_q && data == KEY_MID)  begin st_d = SQ_E5; ok_c = 1'b1; end
         SQ_E5: begin
            if (at_p && data == KEY_ERASE) begin
               ok_c  = 1'b1;
               ers_c = 1'b1;
            end
         end
         default: st_d = SQ_IDLE;
      endcase
   end

   assign step_ok   = ev && en && ok_c;
   assign do_unlock = ev && en && unl_c;
   assign do_erase  = ev && en && ers_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      st_q <= SQ_IDLE;
      else if (!en)    st_q <= SQ_IDLE;
      else if (ev)     st_q <= st_d;
   end
endmodule

// File: rtl/pgw_pagebuf.sv
module pgw_pagebuf #(
   parameter int PAGE_W = 7
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr,
   input  logic [PAGE_W-1:0]       off,
   input  logic [7:0]              wdata,
   input  logic                    clr,
   output logic [(1<<PAGE_W)-1:0]  valid,
   output logic [(8<<PAGE_W)-1:0]  image,
   output logic                    any
);
   localparam int PB = 1 << PAGE_W;

   logic [7:0]    lane_q [PB];
   logic [PB-1:0] valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   valid_q <= '0;
      else if (clr) valid_q <= '0;
      else if (wr)  valid_q[off] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr) lane_q[off] <= wdata;
   end

   for (genvar g = 0; g < PB; g++) begin : g_lane
      assign image[g*8 +: 8] = valid_q[g] ? lane_q[g] : 8'hFF;
   end

   assign valid = valid_q;
   assign any   = |valid_q;
endmodule

// File: rtl/pgw_timer.sv
module pgw_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic             hit
);
   localparam logic [CNT_W-1:0] ONE = 1;

   logic [CNT_W-1:0] cnt_q;

   assign hit = run && !clr && (cnt_q == limit - ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (clr || hit)  cnt_q <= '0;
      else if (run)         cnt_q <= cnt_q + ONE;
   end
endmodule

// File: rtl/pgw_eeprom.sv
module pgw_eeprom
   import pgw_pkg::*;
#(
   parameter int ADDR_W    = 10,
   parameter int PAGE_W    = 7,
   parameter int IDLE_CYC  = 10000,
   parameter int PROG_CYC  = 250000,
   parameter int ERASE_CYC = 500000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   inout  wire  [7:0]        dq,
   output logic              busy
);
   localparam int MEM_BYTES = 1 << ADDR_W;
   localparam int PB        = 1 << PAGE_W;
   localparam int PGA_W     = ADDR_W - PAGE_W;
   localparam int OP_MAX    = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
   localparam int OP_W      = $clog2(OP_MAX + 1);
   localparam int IDL_W     = $clog2(IDLE_CYC + 1);

   if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
      $error("PAGE_W must lie between 1 and ADDR_W-1");
   end
   if (ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W above 16 is not supported");
   end
   if (IDLE_CYC < 2 || PROG_CYC < 2 || ERASE_CYC < 2) begin : g_bad_time
      $error("cycle counts must be at least 2");
   end

   logic              wr_act, rd_act, act_q, rd_q;
   logic [ADDR_W-1:0] a_lat;
   logic [7:0]        d_lat;
   logic              ev, writable, buf_we;
   logic              step_ok, do_unlock, do_erase;
   logic              prot_on, unlock, last7, tog_q;
   logic [PGA_W-1:0]  page_q;
   op_e               op_q;
   logic [PB-1:0]     buf_valid;
   logic [8*PB-1:0]   image;
   logic              buf_any;
   logic              idle_hit, op_hit, prog_done, erase_done;
   logic [OP_W-1:0]   op_limit;
   logic [7:0]        status, rdata;
   logic [7:0]        mem [MEM_BYTES];

   assign wr_act = !ce_n && !we_n && oe_n;
   assign rd_act = !ce_n && !oe_n;
   assign busy   = (op_q != OP_IDLE);
   assign ev     = act_q && !wr_act && !busy;
   assign writable = !prot_on || unlock;
   assign buf_we = ev && !step_ok && writable;

   pgw_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .ev(ev), .en(!buf_any),
      .addr(a_lat), .data(d_lat),
      .step_ok(step_ok), .do_unlock(do_unlock), .do_erase(do_erase)
   );

   pgw_pagebuf #(.PAGE_W(PAGE_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr(buf_we), .off(a_lat[PAGE_W-1:0]),
      .wdata(d_lat), .clr(prog_done),
      .valid(buf_valid), .image(image), .any(buf_any)
   );

   pgw_timer #(.CNT_W(IDL_W)) u_idle (
      .clk(clk), .rst_n(rst_n), .clr(buf_we),
      .run(buf_any && !wr_act && !busy),
      .limit(IDL_W'(IDLE_CYC)), .hit(idle_hit)
   );

   assign op_limit = (op_q == OP_ERASE) ? OP_W'(ERASE_CYC) : OP_W'(PROG_CYC);

   pgw_timer #(.CNT_W(OP_W)) u_op (
      .clk(clk), .rst_n(rst_n), .clr(idle_hit || do_erase),
      .run(busy), .limit(op_limit), .hit(op_hit)
   );

   assign prog_done  = op_hit && (op_q == OP_PROG);
   assign erase_done = op_hit && (op_q == OP_ERASE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         rd_q    <= 1'b0;
         a_lat   <= '0;
         d_lat   <= '0;
         prot_on <= 1'b0;
         unlock  <= 1'b0;
         page_q  <= '0;
         last7   <= 1'b0;
         tog_q   <= 1'b0;
         op_q    <= OP_IDLE;
      end else begin
         act_q <= wr_act;
         rd_q  <= rd_act;
         if (wr_act && !act_q) a_lat <= addr;
         if (wr_act)           d_lat <= dq;
         if (do_unlock) begin
            prot_on <= 1'b1;
            unlock  <= 1'b1;
         end
         if (prog_done) unlock <= 1'b0;
         if (buf_we) begin
            page_q <= a_lat[ADDR_W-1:PAGE_W];
            last7  <= d_lat[7];
         end
         if (idle_hit)      op_q <= OP_PROG;
         else if (do_erase) op_q <= OP_ERASE;
         else if (op_hit)   op_q <= OP_IDLE;
         if (rd_q && !rd_act && busy) tog_q <= !tog_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
      end else if (erase_done) begin
         for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
      end else if (prog_done) begin
         for (int i = 0; i < PB; i++) mem[{page_q, PAGE_W'(i)}] <= image[i*8 +: 8];
      end
   end

   assign status = (op_q == OP_PROG) ? {!last7, tog_q, 6'b0} : {1'b0, tog_q, 6'b0};
   assign rdata  = busy ? status : mem[addr];
   assign dq     = rd_act ? rdata : {8{1'bz}};
endmodule

// File: rtl/pgw_eeprom_chk.sv
module pgw_eeprom_chk
   import pgw_pkg::*;
#(
   parameter int PB = 128
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          prot_on,
   input logic          unlock,
   input op_e           op_q,
   input logic [PB-1:0] buf_valid,
   input logic          rd_q,
   input logic          rd_act,
   input logic          tog_q
);
   AST_PROT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(prot_on) |-> prot_on);                                        // R6

   AST_LOCKED_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_on && !unlock && !busy) |=> $stable(buf_valid));              // R7

   AST_UNLOCK_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && $past(op_q) == OP_PROG) |-> !unlock);               // R8

   AST_BUF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(buf_valid));                      // R10

   AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_q && !rd_act && busy) |=> (tog_q != $past(tog_q)));             // R11
endmodule

bind pgw_eeprom pgw_eeprom_chk #(.PB(PB)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .prot_on(prot_on),
   .unlock(unlock), .op_q(op_q), .buf_valid(buf_valid),
   .rd_q(rd_q), .rd_act(rd_act), .tog_q(tog_q)
);

// File: tb/pgw_eeprom_test.sv
module pgw_eeprom_test;
   localparam int AW    = 10;
   localparam int IDLE  = 20;
   localparam int PROG  = 30;
   localparam int ERASE = 40;
   localparam logic [AW-1:0] KP = 10'h155;
   localparam logic [AW-1:0] KQ = 10'h2AA;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic          tb_en = 1'b0;
   logic [7:0]    tb_d = 8'h00;
   wire  [7:0]    dq;
   logic          busy;

   int checks = 0;
   int errors = 0;
   int busy_cyc = 0;

   assign dq = tb_en ? tb_d : 8'hzz;

   always #10 clk = !clk;

   pgw_eeprom #(.ADDR_W(AW), .PAGE_W(7), .IDLE_CYC(IDLE), .PROG_CYC(PROG),
                .ERASE_CYC(ERASE)) uut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .dq(dq), .busy(busy)
   );

   always @(negedge clk) if (busy) busy_cyc++;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] pa(input int pg, input int off);
      return {pg[2:0], off[6:0]};
   endfunction

   task automatic load(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; tb_d = d; tb_en = 1'b1; ce_n = 1'b0; we_n = 1'b0;
      @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1; addr = ~a; tb_d = ~d;
      @(negedge clk);
      tb_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
      @(negedge clk);
      addr = a; ce_n = 1'b0; oe_n = 1'b0;
      #5 v = dq;
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_start(output int n);
      n = 0;
      while (!busy && n < 500) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic wait_end();
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk("R3 busy after reset", int'(busy), 0);
      rd(pa(4, 9), v);
      chk("R1/R3 erased read", v, 8'hFF);
      @(negedge clk);
      addr = pa(4, 9); ce_n = 1'b0; oe_n = 1'b1; tb_en = 1'b1; tb_d = 8'hAA;
      #5 chk("R1 no drive with oe_n high", dq, 8'hAA);
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b0;
      #5 chk("R1 no drive with ce_n high", dq, 8'hAA);
      @(negedge clk);
      oe_n = 1'b1; tb_en = 1'b0;
   endtask

   task automatic t_plain();
      logic [7:0] v1, v2;
      int n;
      load(pa(1, 3), 8'h12);
      load(pa(1, 3), 8'h34);
      load(pa(2, 5), 8'h1C);
      busy_cyc = 0;
      wait_start(n);
      chk("R3 launch delay", n, IDLE);
      rd(pa(2, 5), v1);
      rd(pa(2, 5), v2);
      chk("R11 status bit7", int'(v1[7]), 1);
      chk("R11 status low bits", int'(v1[5:0]), 0);
      chk("R11 toggle", int'(v1[6] != v2[6]), 1);
      load(pa(2, 0), 8'h00);
      wait_end();
      chk("R10 busy length", busy_cyc, PROG);
      rd(pa(2, 3), v1); chk("R4/R5 overwritten byte", v1, 8'h34);
      rd(pa(2, 5), v1); chk("R2/R5 last byte", v1, 8'h1C);
      rd(pa(2, 0), v1); chk("R10 load while busy ignored", v1, 8'hFF);
      rd(pa(2, 9), v1); chk("R5 unloaded offset FF", v1, 8'hFF);
      rd(pa(1, 3), v1); chk("R5 earlier page untouched", v1, 8'hFF);
   endtask

   task automatic t_retrigger();
      logic [7:0] v;
      int n;
      load(pa(0, 16), 8'h61);
      idle(IDLE - 2);
      load(pa(0, 17), 8'h62);
      chk("R4 no launch at collision", int'(busy), 0);
      wait_start(n);
      chk("R4 launch after retrigger", n, IDLE);
      wait_end();
      rd(pa(0, 16), v); chk("R4 first byte kept", v, 8'h61);
      rd(pa(0, 17), v); chk("R4 second byte", v, 8'h62);
   endtask

   task automatic t_protect();
      logic [7:0] v;
      int n;
      load(KP, 8'hAA); load(KQ, 8'h55); load(KP, 8'hA0);
      load(pa(3, 0), 8'h11);
      wait_start(n);
      chk("R6 page after key launches", n, IDLE);
      wait_end();
      rd(pa(3, 0), v); chk("R6 keyed byte", v, 8'h11);
      rd(KP, v);       chk("R6 key byte not stored", v, 8'hFF);
      rd(KQ, v);       chk("R6 key byte not stored", v, 8'hFF);
   endtask

   task automatic t_locked();
      logic [7:0] v;
      load(pa(4, 1), 8'h22);
      idle(IDLE + 5);
      chk("R7 no launch when locked", int'(busy), 0);
      rd(pa(4, 1), v); chk("R7 locked load dropped", v, 8'hFF);
   endtask

   task automatic t_mismatch();
      logic [7:0] v;
      int n;
      load(KP, 8'hAA); load(KQ, 8'h55); load(KP, 8'hA1);
      load(pa(6, 7), 8'h44);
      idle(IDLE + 5);
      chk("R9 broken key no launch", int'(busy), 0);
      rd(pa(6, 7), v); chk("R9 broken key no write", v, 8'hFF);
      load(KP, 8'hAA); load(KQ, 8'h56);
      load(KP, 8'hAA); load(KQ, 8'h55); load(KP, 8'hA0);
      load(pa(6, 2), 8'h33);
      wait_start(n);
      chk("R9 key after mismatch", n, IDLE);
      wait_end();
      rd(pa(6, 2), v); chk("R9 write after recovery", v, 8'h33);
   endtask

   task automatic t_erase();
      logic [7:0] v1, v2;
      int n;
      busy_cyc = 0;
      load(KP, 8'hAA); load(KQ, 8'h55); load(KP, 8'h80);
      load(KP, 8'hAA); load(KQ, 8'h55); load(KP, 8'h10);
      chk("R12 erase starts", int'(busy), 1);
      rd(pa(0, 0), v1);
      rd(pa(0, 0), v2);
      chk("R12 erase status bit7", int'(v1[7]), 0);
      chk("R12 erase toggle", int'(v1[6] != v2[6]), 1);
      wait_end();
      n = busy_cyc;
      chk("R12 erase length", n, ERASE);
      rd(pa(2, 3), v1); chk("R12 erased", v1, 8'hFF);
      rd(pa(6, 2), v1); chk("R12 erased", v1, 8'hFF);
   endtask

   task automatic t_matchhold();
      logic [7:0] v;
      int n;
      load(KP, 8'hAA); load(KQ, 8'h55); load(KP, 8'hA0);
      load(pa(7, 0), 8'h01);
      load(KP, 8'hAA); load(KQ, 8'h55); load(KP, 8'hA0);
      wait_start(n);
      chk("R13 launch", n, IDLE);
      wait_end();
      rd(pa(2, 0), v);  chk("R13 page of last load", v, 8'h01);
      rd(pa(2, 42), v); chk("R13 key-shaped data kept", v, 8'h55);
      rd(KP, v);        chk("R13 key-shaped data kept", v, 8'hA0);
      rd(pa(7, 0), v);  chk("R5 old page untouched", v, 8'hFF);
      load(pa(1, 0), 8'h77);
      idle(IDLE + 5);
      chk("R8 locked again", int'(busy), 0);
      rd(pa(1, 0), v); chk("R8 relocked load dropped", v, 8'hFF);
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_plain();
      t_retrigger();
      t_protect();
      t_locked();
      t_mismatch();
      t_erase();
      t_matchhold();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule